// File: doc/BRIEF.md
# Saturating Signed Fixed-Point Multiplier

This block multiplies two signed two's-complement fixed-point operands of `W` bits each. A compile-time parameter `FRAC` gives the number of fractional bits, shared by both operands and the result. The block first forms the complete `2W`-bit product, so no precision is lost at that stage. It then applies an arithmetic right shift by `FRAC` and truncates the shifted value to `W` bits. If the true scaled value does not fit in the signed `W`-bit range, the block clamps it to the nearest limit and raises a saturation flag.

An operand pair is offered together with an input strobe. One clock later the block presents the result, the saturation flag and an output strobe, all from registers. Cycles without a strobe leave the result registers unchanged.

Overflow is found by looking at the product bits from the top bit down to the bit that becomes the result's sign. When `FRAC` is exactly `W/2`, this test is split in two. The top `W/2` bits form the upper half. The sign bit of the next `W/2` bits is the one extra bit that decides the boundary case. An upper half equal to minus one together with a non-negative lower half counts as negative overflow.

Top module: `sat_fxmul`

## Requirements
- R1: When no clamp applies, a strobed operand pair gives out_data equal to the low W bits of (a*b) shifted right arithmetically by FRAC, with a and b signed and the product held at 2W bits. out_sat is 0 in this case.
- R2: When the scaled product is below -2^(W-1), out_data is the most negative value (bit W-1 set, all other bits clear; 0x80 for W=8) and out_sat is 1. Example with W=8, FRAC=4: 0x80 times 0x20 has the wide product 0xF000 and gives 0x80, not 0x00.
- R3: When the scaled product is above 2^(W-1)-1, out_data is the most positive value (0x7F for W=8) and out_sat is 1.
- R4: Boundary products do not clamp when they fit. An upper half of minus one with the lower-half sign bit set yields the negative result unchanged (0x80 x 0x10 -> 0x80, out_sat 0). An upper half of zero with the lower-half sign bit clear yields the positive result unchanged (0x7F x 0x10 -> 0x7F, out_sat 0).
- R5: out_valid is high in exactly the cycle after a cycle with in_valid high. out_data and out_sat for that pair appear in that same cycle.
- R6: After a cycle with in_valid low and reset low, out_valid is 0, and out_data and out_sat keep their previous values.
- R7: A synchronous active-high reset clears out_valid, out_sat and out_data to 0 at the next clock edge.
- R8: Truncation rounds toward negative infinity. With FRAC=4, 0xFF times 0x01 gives 0xFF (-1 LSB), not 0.
- R9: When out_sat is 1, the sign of out_data equals the XOR of the two operand signs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand pair strobe |
| op_a | input | W | Signed fixed-point operand A |
| op_b | input | W | Signed fixed-point operand B |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| out_data | output | W | Scaled, truncated and clamped product |
| out_sat | output | 1 | High when the result was clamped |

## Verification
The clamp decision and the truncating shift act on the same product in the same cycle. The sharpest case is a product whose upper half is minus one or zero, where the lower-half sign bit alone decides between wrapping and clamping. Directed operands reach each side of both boundaries:

- 0x80 x 0x20 gives an upper half of minus one and a zero lower half.
- 0x80 x 0x10 gives an upper half of minus one and a lower half with its sign bit set.
- 0x40 x 0x20 gives an upper half of zero and a lower half with its sign bit set.
- 0x7F x 0x10 gives an upper half of zero and a lower half with its sign bit clear.

Seeded random pairs fill in the rest. Each result and flag is compared with a bench model that uses wide integer multiplication, a floor division by 2^FRAC and explicit clamping.

// File: rtl/sat_fxmul_pkg.sv
package sat_fxmul_pkg;
  typedef enum logic [1:0] {
    OVF_NONE = 2'd0,
    OVF_NEG  = 2'd1,
    OVF_POS  = 2'd2
  } ovf_e;

  // Number of product bits, from the top down to the result sign bit.
  function automatic int guard_bits(input int w, input int f);
    return w - f + 1;
  endfunction
endpackage

// File: rtl/sat_fxmul_prod.sv
module sat_fxmul_prod #(
  parameter int W = 8
) (
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [2*W-1:0] p
);
  localparam int PW = 2 * W;

  logic signed [PW-1:0] a_ext;
  logic signed [PW-1:0] b_ext;

  always_comb begin
    a_ext = PW'($signed(a));
    b_ext = PW'($signed(b));
    p     = a_ext * b_ext;
  end
endmodule

// File: rtl/sat_fxmul_ovf.sv
module sat_fxmul_ovf
  import sat_fxmul_pkg::*;
#(
  parameter int W    = 8,
  parameter int FRAC = 4
) (
  input  logic [2*W-1:0] p,
  output ovf_e           kind
);
  localparam int PW   = 2 * W;
  localparam int HALF = W / 2;
  localparam int GB   = guard_bits(W, FRAC);

  logic neg;
  logic pos;

  generate
    if ((W % 2 == 0) && (FRAC == HALF)) begin : g_split
      // Upper half of the guard field, and the sign of the half below it.
      logic [HALF-1:0] hh;
      logic            hl_sign;
      always_comb begin
        hh      = p[PW-1 -: HALF];
        hl_sign = p[PW-1-HALF];
        // Upper half below minus one, or equal to minus one with a
        // non-negative lower half.
        neg = (hh[HALF-1] && !(&hh)) || ((&hh) && !hl_sign);
        // Upper half above zero, or equal to zero with a negative lower half.
        pos = (!hh[HALF-1] && (|hh)) || (!(|hh) && hl_sign);
      end
    end else begin : g_field
      logic [GB-1:0] fld;
      always_comb begin
        fld = p[PW-1 -: GB];
        neg = fld[GB-1] && !(&fld);
        pos = !fld[GB-1] && (|fld);
      end
    end
  endgenerate

  always_comb begin
    if (neg)      kind = OVF_NEG;
    else if (pos) kind = OVF_POS;
    else          kind = OVF_NONE;
  end
endmodule

// File: rtl/sat_fxmul_clamp.sv
module sat_fxmul_clamp
  import sat_fxmul_pkg::*;
#(
  parameter int W    = 8,
  parameter int FRAC = 4
) (
  input  logic [2*W-1:0] p,
  input  ovf_e           kind,
  output logic [W-1:0]   res,
  output logic           sat
);
  localparam int PW = 2 * W;
  localparam logic [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};

  logic signed [PW-1:0] shifted;

  always_comb begin
    shifted = $signed(p) >>> FRAC;
    unique case (kind)
      OVF_NEG: begin res = MINV;             sat = 1'b1; end
      OVF_POS: begin res = MAXV;             sat = 1'b1; end
      default: begin res = shifted[W-1:0];   sat = 1'b0; end
    endcase
  end
endmodule

// File: rtl/sat_fxmul.sv
module sat_fxmul
  import sat_fxmul_pkg::*;
#(
  parameter int W    = 8,
  parameter int FRAC = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  output logic         out_valid,
  output logic [W-1:0] out_data,
  output logic         out_sat
);
  localparam int PW = 2 * W;

  logic [PW-1:0] prod;
  ovf_e          kind;
  logic [W-1:0]  res_c;
  logic          sat_c;

  sat_fxmul_prod #(.W(W)) u_prod (
    .a(op_a), .b(op_b), .p(prod)
  );

  sat_fxmul_ovf #(.W(W), .FRAC(FRAC)) u_ovf (
    .p(prod), .kind(kind)
  );

  sat_fxmul_clamp #(.W(W), .FRAC(FRAC)) u_clamp (
    .p(prod), .kind(kind), .res(res_c), .sat(sat_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_sat   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_data <= res_c;
        out_sat  <= sat_c;
      end
    end
  end
endmodule

// File: rtl/sat_fxmul_chk.sv
module sat_fxmul_chk #(
  parameter int W    = 8,
  parameter int FRAC = 4
) (
  input logic         clk,
  input logic         rst,
  input logic         in_valid,
  input logic [W-1:0] op_a,
  input logic [W-1:0] op_b,
  input logic         out_valid,
  input logic [W-1:0] out_data,
  input logic         out_sat
);
  localparam logic [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};

  p_sat_min_r2: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_sat && out_data[W-1]) |-> (out_data == MINV));

  p_sat_max_r3: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_sat && !out_data[W-1]) |-> (out_data == MAXV));

  p_latency_r5: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  p_idle_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(out_data) && $stable(out_sat)));

  p_reset_r7: assert property (@(posedge clk)
    rst |=> (!out_valid && !out_sat && out_data == '0));

  p_sat_sign_r9: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (!out_sat || (out_data[W-1] == ($past(op_a[W-1]) ^ $past(op_b[W-1])))));
endmodule

bind sat_fxmul sat_fxmul_chk #(.W(W), .FRAC(FRAC)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
  .out_valid(out_valid), .out_data(out_data), .out_sat(out_sat)
);

// File: tb/sat_fxmul_bench.sv
`timescale 1ns/1ps
module sat_fxmul_bench;
  localparam int W    = 8;
  localparam int FRAC = 4;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [W-1:0] op_a = '0;
  logic [W-1:0] op_b = '0;
  logic         out_valid;
  logic [W-1:0] out_data;
  logic         out_sat;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  sat_fxmul #(.W(W), .FRAC(FRAC)) u_sat_fxmul (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .out_valid(out_valid), .out_data(out_data), .out_sat(out_sat)
  );

  // Reference model: wide integer product, floor scaling, then clamping.
  function automatic logic [W:0] model(input logic [W-1:0] a, input logic [W-1:0] b);
    longint pa, pb, pr, q, lo, hi;
    logic sat;
    pa = longint'($signed(a));
    pb = longint'($signed(b));
    pr = pa * pb;
    q  = pr >>> FRAC;
    lo = -(longint'(1) << (W - 1));
    hi = (longint'(1) << (W - 1)) - 1;
    sat = 1'b0;
    if (q < lo) begin q = lo; sat = 1'b1; end
    if (q > hi) begin q = hi; sat = 1'b1; end
    return {sat, q[W-1:0]};
  endfunction

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(input string req, input logic [W-1:0] a, input logic [W-1:0] b);
    logic [W:0] e;
    e = model(a, b);
    @(negedge clk);
    in_valid = 1'b1; op_a = a; op_b = b;
    @(negedge clk);
    in_valid = 1'b0;
    check(req, out_data, e[W-1:0]);
    check(req, {{(W-1){1'b0}}, out_sat}, {{(W-1){1'b0}}, e[W]});
    check("R5", {{(W-1){1'b0}}, out_valid}, {{(W-1){1'b0}}, 1'b1});
  endtask

  initial begin
    logic [W-1:0] hold_d;
    logic         hold_s;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R7", out_data, '0);
    check("R7", {7'd0, out_valid}, 8'd0);
    check("R7", {7'd0, out_sat}, 8'd0);

    apply("R2", 8'h80, 8'h20);   // product 0xF000, must clamp low
    apply("R2", 8'h90, 8'h40);
    apply("R3", 8'h7F, 8'h7F);
    apply("R3", 8'h80, 8'h80);
    apply("R3", 8'h40, 8'h20);   // product 0x0800, clamps high
    apply("R4", 8'h80, 8'h10);   // product 0xF800, fits
    apply("R4", 8'h7F, 8'h10);   // product 0x07F0, fits
    apply("R8", 8'hFF, 8'h01);
    apply("R1", 8'h18, 8'h28);
    apply("R1", 8'h00, 8'h80);
    apply("R9", 8'h81, 8'h7F);

    // Idle cycle: outputs hold
    hold_d = out_data;
    hold_s = out_sat;
    @(negedge clk);
    op_a = 8'h55; op_b = 8'h33;
    @(negedge clk);
    check("R6", out_data, hold_d);
    check("R6", {7'd0, out_sat}, {7'd0, hold_s});
    check("R6", {7'd0, out_valid}, 8'd0);

    for (int i = 0; i < 300; i++) begin
      apply("R1", 8'($urandom), 8'($urandom));
    end

    // Reset mid-run
    apply("R3", 8'h7F, 8'h7F);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R7", out_data, '0);
    check("R7", {7'd0, out_sat}, 8'd0);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule